// File: doc/BRIEF.md
# Delay-Compensated Sampling Channel

This block carries results from one producer task to one consumer task by sampling. Each time the producer completes an occurrence, its data word is pushed into a shift buffer. Older words move one slot deeper, and the deepest word falls off the end. The consumer never waits and never removes anything. Each time the consumer starts an occurrence, it takes one word from the buffer.

The slot the consumer reads is not fixed. A counter tracks producer occurrences that have started but not yet completed. The read position is the configured logical delay minus that count. This cancels the extra completions that a zero-duration specification would already have seen, so the consumer gets the same word the ideal specification would have delivered.

If the computed position falls outside the buffer, the block clamps it to the nearest real slot and flags the sample as faulty. A small sampler state machine presents the result. It has three states:

- `SMP_IDLE`: nothing has been sampled since reset.
- `SMP_FRESH`: a word was taken on the previous edge.
- `SMP_HOLD`: the last word is being held.

Its transitions are:

- `SMP_IDLE`→`SMP_FRESH` on a consumer start.
- `SMP_FRESH`→`SMP_FRESH` on back-to-back starts.
- `SMP_FRESH`→`SMP_HOLD` when no start follows.
- `SMP_HOLD`→`SMP_FRESH` on the next start.

Top module: `dcs_channel`

## Requirements
- R1: A producer completion writes the data word into position 1, the newest slot. Every older word moves one position deeper, and the word in position DEPTH is discarded.
- R2: Without a producer completion the buffer contents do not change. Consumer reads are non-destructive, so two reads of the same position with no completion between them return the same word.
- R3: The in-flight count rises by one on a producer start and falls by one on a producer completion. It saturates at DEPTH and at 0.
- R4: A producer start and a producer completion in the same cycle leave the in-flight count unchanged. The buffer still shifts.
- R5: On a consumer start, the read position (1 = newest) is LOG_DELAY minus the in-flight count. The position uses the count and the buffer contents from before any update in that same cycle. The selected word appears on `sample_data_o` in the following cycle.
- R6: If the computed position is below 1, the block reads position 1 and raises `index_fault_o` with that sample.
- R7: If the computed position exceeds DEPTH, the block reads position DEPTH and raises `index_fault_o` with that sample.
- R8: `sample_fresh_o` is high for exactly the one cycle after each consumer start. `sample_data_o` and `index_fault_o` hold their values until the next consumer start.
- R9: After reset, all buffer slots hold 0, the in-flight count is 0, and all outputs are 0.
- R10: With the default parameters (DEPTH 4, LOG_DELAY 3), a serialized producer never causes a fault. Serialized means the in-flight count stays at 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prod_start_i | input | 1 | Producer occurrence start strobe |
| prod_done_i | input | 1 | Producer occurrence completion strobe; writes `prod_data_i` |
| prod_data_i | input | DATA_W | Producer result word |
| cons_start_i | input | 1 | Consumer occurrence start strobe; takes a sample |
| sample_data_o | output | DATA_W | Sampled word, held between samples |
| sample_fresh_o | output | 1 | High in the cycle after a sample is taken |
| index_fault_o | output | 1 | The held sample came from a clamped position |

## Verification
The bench targets same-cycle collisions:

- A start and a completion together. A design that counted both would drift the read position by one on every overlap.
- A consumer start coinciding with a completion. A design that used the post-update count or buffer would return the word one slot too new.

Overlapping producer occurrences push the position below 1. A design without clamping would index garbage or miss the fault flag. A second, shallow instance with a large delay pushes the position past the deepest slot. In that instance, a design that failed to drop the oldest word, or failed to clamp the position, would return the wrong word.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    // Sampler presentation states
    typedef enum logic [1:0] {
        SMP_IDLE  = 2'd0,
        SMP_FRESH = 2'd1,
        SMP_HOLD  = 2'd2
    } smp_state_e;

endpackage

// File: rtl/dcs_shift_buf.sv
module dcs_shift_buf #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] slot_o [DEPTH]
);

    // Slot 0 is the newest word; each completion ripples the chain deeper.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slot_o[0] <= '0;
                else if (push_i)
                    slot_o[0] <= din_i;
            end

            assert_head_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
                push_i |=> slot_o[0] == $past(din_i));
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slot_o[g] <= '0;
                else if (push_i)
                    slot_o[g] <= slot_o[g-1];
            end

            assert_shift_deeper_R1: assert property (@(posedge clk) disable iff (!rst_n)
                push_i |=> slot_o[g] == $past(slot_o[g-1]));
        end

        assert_slot_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !push_i |=> $stable(slot_o[g]));
    end

endmodule

// File: rtl/dcs_inflight_cnt.sv
module dcs_inflight_cnt #(
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             done_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else begin
            unique case ({start_i, done_i})
                2'b10:   if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
                2'b01:   if (cnt_o != '0)      cnt_o <= cnt_o - 1'b1;
                default: ;  // both or neither: count unchanged
            endcase
        end
    end

    assert_both_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && done_i) |=> $stable(cnt_o));

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= CNT_MAX);

    assert_cnt_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !done_i && cnt_o < CNT_MAX) |=> cnt_o == $past(cnt_o) + 1'b1);

endmodule

// File: rtl/dcs_index_calc.sv
module dcs_index_calc #(
    parameter int DEPTH     = 4,
    parameter int LOG_DELAY = 3,
    parameter int CNT_W     = $clog2(DEPTH + 1),
    parameter int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             fault_o
);

    // Position is 1-based (1 = newest); idx_o is the 0-based slot.
    always_comb begin
        int pos;
        pos = LOG_DELAY - int'(cnt_i);
        if (pos < 1) begin
            idx_o   = '0;
            fault_o = 1'b1;
        end else if (pos > DEPTH) begin
            idx_o   = IDX_W'(DEPTH - 1);
            fault_o = 1'b1;
        end else begin
            idx_o   = IDX_W'(pos - 1);
            fault_o = 1'b0;
        end
    end

endmodule

// File: rtl/dcs_sampler.sv
module dcs_sampler
    import dcs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    parameter int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [DATA_W-1:0] slot_i [DEPTH],
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              fault_i,
    output logic [DATA_W-1:0] data_o,
    output logic              fresh_o,
    output logic              fault_o
);

    smp_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SMP_IDLE:  if (take_i) state_d = SMP_FRESH;
            SMP_FRESH: state_d = take_i ? SMP_FRESH : SMP_HOLD;
            SMP_HOLD:  if (take_i) state_d = SMP_FRESH;
            default:   state_d = SMP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SMP_IDLE;
        else
            state_q <= state_d;
    end

    // Output registers: capture pre-update buffer and index on a start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o  <= '0;
            fault_o <= 1'b0;
        end else if (take_i) begin
            data_o  <= slot_i[idx_i];
            fault_o <= fault_i;
        end
    end

    assign fresh_o = (state_q == SMP_FRESH);

    assert_fresh_after_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> fresh_o);

    assert_fresh_only_after_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> !fresh_o);

    assert_sample_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> ($stable(data_o) && $stable(fault_o)));

endmodule

// File: rtl/dcs_channel.sv
module dcs_channel #(
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 4,
    parameter int LOG_DELAY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prod_start_i,
    input  logic              prod_done_i,
    input  logic [DATA_W-1:0] prod_data_i,
    input  logic              cons_start_i,
    output logic [DATA_W-1:0] sample_data_o,
    output logic              sample_fresh_o,
    output logic              index_fault_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] slots [DEPTH];
    logic [CNT_W-1:0]  inflight;
    logic [IDX_W-1:0]  rd_idx;
    logic              rd_fault;

    dcs_shift_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (prod_done_i),
        .din_i  (prod_data_i),
        .slot_o (slots)
    );

    dcs_inflight_cnt #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (prod_start_i),
        .done_i  (prod_done_i),
        .cnt_o   (inflight)
    );

    dcs_index_calc #(
        .DEPTH(DEPTH), .LOG_DELAY(LOG_DELAY), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_idx (
        .cnt_i   (inflight),
        .idx_o   (rd_idx),
        .fault_o (rd_fault)
    );

    dcs_sampler #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_smp (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (cons_start_i),
        .slot_i  (slots),
        .idx_i   (rd_idx),
        .fault_i (rd_fault),
        .data_o  (sample_data_o),
        .fresh_o (sample_fresh_o),
        .fault_o (index_fault_o)
    );

endmodule

// File: tb/tb_dcs_channel.sv
module tb_dcs_channel;

    localparam int DW    = 8;
    localparam int DEPTH = 4;
    localparam int LD    = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;  // 50 MHz

    logic          rst_n = 1'b0;
    logic          p_start = 1'b0, p_done = 1'b0, c_start = 1'b0;
    logic [DW-1:0] p_data = '0;
    logic [DW-1:0] s_data;
    logic          s_fresh, s_fault;

    logic          w_done = 1'b0, w_cstart = 1'b0;
    logic [DW-1:0] w_data = '0;
    logic [DW-1:0] ws_data;
    logic          ws_fresh, ws_fault;

    dcs_channel #(.DATA_W(DW), .DEPTH(DEPTH), .LOG_DELAY(LD)) dut (
        .clk(clk), .rst_n(rst_n), .prod_start_i(p_start), .prod_done_i(p_done),
        .prod_data_i(p_data), .cons_start_i(c_start), .sample_data_o(s_data),
        .sample_fresh_o(s_fresh), .index_fault_o(s_fault)
    );

    // Shallow instance whose delay exceeds its depth
    dcs_channel #(.DATA_W(DW), .DEPTH(2), .LOG_DELAY(3)) dut_wide (
        .clk(clk), .rst_n(rst_n), .prod_start_i(1'b0), .prod_done_i(w_done),
        .prod_data_i(w_data), .cons_start_i(w_cstart), .sample_data_o(ws_data),
        .sample_fresh_o(ws_fresh), .index_fault_o(ws_fault)
    );

    typedef struct packed { logic [DW-1:0] d; logic f; } exp_t;

    exp_t    expq[$];
    string   tagq[$];
    int      mbuf[DEPTH];
    int      mcnt = 0;
    int      checks = 0, fails = 0;
    bit      finished = 1'b0;
    logic [DW-1:0] last_d = '0;
    logic          last_f = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Driver: applies one cycle of stimulus and predicts from the requirements
    task automatic step(input logic ps, input logic pd, input logic [DW-1:0] d,
                        input logic cs, input string tag);
        @(negedge clk);
        p_start = ps; p_done = pd; p_data = d; c_start = cs;
        if (cs) begin
            int   pos;
            logic f;
            pos = LD - mcnt;
            f   = 1'b0;
            if (pos < 1) begin pos = 1; f = 1'b1; end
            else if (pos > DEPTH) begin pos = DEPTH; f = 1'b1; end
            expq.push_back('{d: DW'(mbuf[pos-1]), f: f});
            tagq.push_back(tag);
        end
        if (pd) begin
            for (int i = DEPTH - 1; i > 0; i--) mbuf[i] = mbuf[i-1];
            mbuf[0] = int'(d);
        end
        if (ps && !pd && mcnt < DEPTH) mcnt++;
        else if (pd && !ps && mcnt > 0) mcnt--;
    endtask

    // Monitor: compares each fresh sample with the scoreboard head
    always @(posedge clk) begin
        #5;
        if (rst_n && !finished) begin
            if (s_fresh) begin
                if (expq.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R8 unexpected fresh: actual=1 expected=0");
                end else begin
                    exp_t  e;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    check({t, " data"}, 32'(s_data), 32'(e.d));
                    check({t, " fault"}, 32'(s_fault), 32'(e.f));
                    last_d = s_data;
                    last_f = s_fault;
                end
            end else begin
                if (expq.size() != 0) begin
                    checks++; fails++;
                    $display("FAIL R8 missing fresh: actual=0 expected=1");
                    void'(expq.pop_front());
                    void'(tagq.pop_front());
                end
                check("R8 data held", 32'(s_data), 32'(last_d));
                check("R8 fault held", 32'(s_fault), 32'(last_f));
            end
        end
    end

    initial begin
        #4000000;
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mbuf[i] = 0;
        repeat (3) @(negedge clk);
        check("R9 reset data", 32'(s_data), 0);
        check("R9 reset fresh", 32'(s_fresh), 0);
        check("R9 reset fault", 32'(s_fault), 0);
        check("R9 reset wide data", 32'(ws_data), 0);
        rst_n = 1'b1;

        step(0, 0, 0, 1, "R9 zeroed buffer read");

        // Serialized producer: count alternates 1/0
        for (int k = 1; k <= 5; k++) begin
            step(1, 0, 0, 0, "");
            step(0, 0, 0, 1, "R10 serial in-flight one");
            step(0, 1, DW'(k * 17), 0, "");
            step(0, 0, 0, 1, "R5 idle count zero");
        end

        // Non-destructive repeated reads
        step(0, 0, 0, 1, "R2 repeat read a");
        step(0, 0, 0, 1, "R2 repeat read b");
        step(0, 0, 0, 0, "");

        // Overlapping producer occurrences
        step(1, 0, 0, 0, "");
        step(1, 0, 0, 0, "");
        step(1, 0, 0, 1, "R5 start with sample uses old count");
        step(0, 0, 0, 1, "R6 below range clamp");
        step(1, 1, 8'h55, 0, "");
        step(0, 0, 0, 1, "R4 count unchanged on start and done");
        step(0, 1, 8'h66, 0, "");
        step(0, 0, 0, 1, "R5 count two");
        step(0, 1, 8'h77, 1, "R5 sample with done uses old buffer");
        step(0, 1, 8'h88, 0, "");
        step(0, 0, 0, 1, "R1 shifted history");

        // Counter saturation at both ends
        step(0, 1, 8'h99, 0, "");
        step(0, 0, 0, 1, "R3 floor at zero");
        for (int k = 0; k < DEPTH + 2; k++) step(1, 0, 0, 0, "");
        step(0, 0, 0, 1, "R3 ceiling sample");
        for (int k = 0; k < DEPTH; k++) step(0, 1, DW'(8'hA0 + k), 0, "");
        step(0, 0, 0, 1, "R3 ceiling then drain");
        repeat (3) step(0, 0, 0, 0, "");

        // Shallow instance: position 3 beyond depth 2
        @(negedge clk); w_done = 1'b1; w_data = 8'hA1;
        @(negedge clk); w_data = 8'hB2;
        @(negedge clk); w_data = 8'hC3;
        @(negedge clk); w_done = 1'b0; w_cstart = 1'b1;
        @(negedge clk); w_cstart = 1'b0;
        check("R7 fresh wide", 32'(ws_fresh), 1);
        check("R7 clamp to deepest slot", 32'(ws_data), 32'h00B2);
        check("R7 fault raised", 32'(ws_fault), 1);
        check("R1 oldest word discarded", 32'(ws_data != 8'hA1), 1);

        repeat (3) step(0, 0, 0, 0, "");
        check("R8 scoreboard drained", 32'(expq.size()), 0);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule